// File: doc/BRIEF.md
# Bus Intercycle Idle Inserter

This block sits between the queue that issues external bus accesses and the sequencer that runs them. It remembers the area number and direction of the last access the sequencer accepted. When the next access targets another area, or turns a read into a write (or a write into a read) inside the same area, it holds the request back for a programmed number of idle clocks before it lets the access through unchanged.

A 16-bit control register sets the idle counts. It holds a 2-bit count field for each area that has one, plus one bit that enables a WAIT input sampled on the falling clock edge. The idle count is always read from the field of the area of the *previous* access. Areas without a field insert no idles when they were the previous area. A power-on reset loads the register. A manual reset keeps the register but forgets the access history.

Top module: `bus_idle_inserter`

## Requirements
- R1: The first access after a power-on or manual reset is accepted with no idle cycles, because there is no previous access.
- R2: An access to the same area and in the same direction as the previous accepted access is accepted in the cycle it is presented (zero added latency).
- R3: When the area differs from the previous accepted access, the block stalls for the number of idles given by the previous area's field.
- R4: A read after a write, or a write after a read, in the same area stalls for the number of idles given by that area's field.
- R5: The field for area n occupies register bits 2n+1:2n and exists for n = 0 and n = 2..6. Code 00 or 01 gives 1 idle, code 10 gives 2 idles and code 11 gives 3 idles.
- R6: When the previous area is 1 or 7 (no field), the next access is accepted with no idles.
- R7: Register bits 14, 3 and 2 always read as 0, and writes to them are ignored.
- R8: A power-on reset sets the register to 0xBFF3. A manual reset leaves the register unchanged.
- R9: When bit 15 is 1, waitOut shows waitIn as sampled on the last falling clock edge. When bit 15 is 0, waitOut is held at 0.
- R10: During idle cycles reqReady and busValid are low. An accepted access appears on busArea, busWrite and busAddr exactly as it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstPor_n | input | 1 | Power-on reset, active low, synchronous |
| rstMan_n | input | 1 | Manual reset, active low, synchronous; clears history only |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 16 | Control register write data |
| cfgRdata | output | 16 | Control register read value |
| reqValid | input | 1 | Access request present |
| reqArea | input | 3 | Area number of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqReady | output | 1 | Request accepted this cycle |
| busValid | output | 1 | Access forwarded to the sequencer |
| busArea | output | 3 | Forwarded area number |
| busWrite | output | 1 | Forwarded direction |
| busAddr | output | ADDR_W | Forwarded address |
| busReady | input | 1 | Sequencer can take an access |
| waitIn | input | 1 | External WAIT input |
| waitOut | output | 1 | WAIT sampled on the falling edge, gated by bit 15 |

## Verification
A sequence of accesses walks through repeated accesses, area changes, turnarounds inside one area, and moves out of and into areas 1 and 7, with a register value that uses all four field codes. The stall count seen for each access shows whether the count was taken from the previous area or the new one, and whether codes 00 and 01 were treated alike. Directed cases separate a power-on reset from a manual reset by the register value and by the idle count of the first access that follows. They also check that the reserved bits stay zero and that WAIT is masked when bit 15 is 0.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int CFG_W       = 16;
  localparam int AREA_W      = 3;
  localparam int NUM_AREAS   = 1 << AREA_W;
  localparam int WAIT_SEL    = 15;
  localparam logic [CFG_W-1:0] CFG_MASK = 16'hBFF3;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setDone;
    logic capture;
  } idleStrobe_t;

  function automatic logic [1:0] codeToIdles(input logic [1:0] code);
    return (code == 2'b00) ? 2'd1 : code;
  endfunction

  function automatic bit areaHasField(input int a);
    return (a == 0) || (a >= 2 && a <= 6);
  endfunction
endpackage

// File: rtl/idle_datapath.sv
module idle_datapath
  import idle_pkg::*;
(
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              rstMan_n,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  input  logic              waitIn,
  output logic              waitOut,
  input  idleStrobe_t       strobe,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  output logic              cntZero,
  output logic              cntOne,
  output logic              idleDone,
  output logic              haveLast,
  output logic              areaMatch,
  output logic              dirMatch,
  output logic [1:0]        prevIdles
);
  logic [CFG_W-1:0]  cfgReg;
  logic [AREA_W-1:0] lastArea;
  logic              lastWrite;
  logic [1:0]        cnt;
  logic              waitFall;
  logic [1:0]        areaIdles [NUM_AREAS];

  always_ff @(posedge clk) begin
    if (!rstPor_n)  cfgReg <= CFG_MASK;
    else if (cfgWe) cfgReg <= cfgWdata & CFG_MASK;
  end

  assign cfgRdata = cfgReg;

  genvar a;
  generate
    for (a = 0; a < NUM_AREAS; a++) begin : g_area
      if (areaHasField(a)) begin : g_field
        assign areaIdles[a] = codeToIdles(cfgReg[2*a +: 2]);
      end else begin : g_none
        assign areaIdles[a] = 2'd0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstPor_n || !rstMan_n) begin
      haveLast  <= 1'b0;
      lastArea  <= '0;
      lastWrite <= 1'b0;
      cnt       <= '0;
      idleDone  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        haveLast  <= 1'b1;
        lastArea  <= reqArea;
        lastWrite <= reqWrite;
      end
      if (strobe.loadCnt)     cnt <= prevIdles - 2'd1;
      else if (strobe.decCnt) cnt <= cnt - 2'd1;
      if (strobe.setDone)      idleDone <= 1'b1;
      else if (strobe.capture) idleDone <= 1'b0;
    end
  end

  always_ff @(negedge clk) begin
    if (!rstPor_n) waitFall <= 1'b0;
    else           waitFall <= waitIn;
  end

  assign waitOut   = cfgReg[WAIT_SEL] & waitFall;
  assign prevIdles = areaIdles[lastArea];
  assign areaMatch = (reqArea == lastArea);
  assign dirMatch  = (reqWrite == lastWrite);
  assign cntZero   = (cnt == 2'd0);
  assign cntOne    = (cnt == 2'd1);
endmodule

// File: rtl/idle_control.sv
module idle_control
  import idle_pkg::*;
(
  input  logic        reqValid,
  input  logic        busReady,
  input  logic        cntZero,
  input  logic        cntOne,
  input  logic        idleDone,
  input  logic        haveLast,
  input  logic        areaMatch,
  input  logic        dirMatch,
  input  logic [1:0]  prevIdles,
  output idleStrobe_t strobe,
  output logic        stall
);
  logic switchSeen;
  logic needIdle;
  logic startIdle;

  assign switchSeen = !areaMatch || !dirMatch;
  assign needIdle   = haveLast && !idleDone && switchSeen && (prevIdles != 2'd0);
  assign startIdle  = cntZero && reqValid && needIdle;
  assign stall      = !cntZero || startIdle;

  always_comb begin
    strobe         = '0;
    strobe.loadCnt = startIdle;
    strobe.decCnt  = !cntZero;
    strobe.setDone = (startIdle && prevIdles == 2'd1) || cntOne;
    strobe.capture = reqValid && busReady && !stall;
  end
endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
  import idle_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              rstMan_n,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  input  logic              reqValid,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              busValid,
  output logic [AREA_W-1:0] busArea,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busReady,
  input  logic              waitIn,
  output logic              waitOut
);
  idleStrobe_t strobe;
  logic        stall;
  logic        cntZero, cntOne, idleDone, haveLast, areaMatch, dirMatch;
  logic [1:0]  prevIdles;

  idle_datapath u_dp (
    .clk(clk), .rstPor_n(rstPor_n), .rstMan_n(rstMan_n),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .waitIn(waitIn), .waitOut(waitOut), .strobe(strobe),
    .reqArea(reqArea), .reqWrite(reqWrite),
    .cntZero(cntZero), .cntOne(cntOne), .idleDone(idleDone),
    .haveLast(haveLast), .areaMatch(areaMatch), .dirMatch(dirMatch),
    .prevIdles(prevIdles)
  );

  idle_control u_ctl (
    .reqValid(reqValid), .busReady(busReady),
    .cntZero(cntZero), .cntOne(cntOne), .idleDone(idleDone),
    .haveLast(haveLast), .areaMatch(areaMatch), .dirMatch(dirMatch),
    .prevIdles(prevIdles), .strobe(strobe), .stall(stall)
  );

  assign reqReady = busReady && !stall;
  assign busValid = reqValid && !stall;
  assign busArea  = reqArea;
  assign busWrite = reqWrite;
  assign busAddr  = reqAddr;
endmodule

// File: rtl/bus_idle_inserter_chk.sv
module bus_idle_inserter_chk
  import idle_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstPor_n,
  input logic              rstMan_n,
  input logic              cfgWe,
  input logic [CFG_W-1:0]  cfgRdata,
  input logic              reqValid,
  input logic [AREA_W-1:0] reqArea,
  input logic              reqWrite,
  input logic              reqReady,
  input logic              busValid,
  input logic              busReady,
  input logic              waitOut
);
  logic              seen;
  logic [AREA_W-1:0] shArea;
  logic              shWrite;
  logic              prevStall;
  logic [2:0]        stallRun;
  logic              blocked;

  assign blocked = reqValid && busReady && !reqReady;

  always_ff @(posedge clk) begin
    if (!rstPor_n || !rstMan_n) begin
      seen <= 1'b0; shArea <= '0; shWrite <= 1'b0;
      prevStall <= 1'b0; stallRun <= '0;
    end else begin
      if (reqValid && reqReady) begin
        seen <= 1'b1; shArea <= reqArea; shWrite <= reqWrite;
      end
      prevStall <= blocked;
      stallRun  <= blocked ? ((stallRun == 3'd7) ? stallRun : stallRun + 3'd1) : 3'd0;
    end
  end

  a_r1_first_free: assert property (@(posedge clk) disable iff (!rstPor_n || !rstMan_n)
    (!seen && reqValid && busReady) |-> reqReady);
  a_r2_no_added_latency: assert property (@(posedge clk) disable iff (!rstPor_n || !rstMan_n)
    (seen && !prevStall && reqValid && busReady && reqArea == shArea && reqWrite == shWrite) |-> reqReady);
  a_r5_idle_bound: assert property (@(posedge clk) disable iff (!rstPor_n || !rstMan_n)
    stallRun <= 3'd3);
  a_r6_fieldless_free: assert property (@(posedge clk) disable iff (!rstPor_n || !rstMan_n)
    (seen && !prevStall && (shArea == 3'd1 || shArea == 3'd7) && reqValid && busReady) |-> reqReady);
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstPor_n)
    (cfgRdata & ~CFG_MASK) == '0);
  a_r8_manual_keeps: assert property (@(posedge clk) disable iff (!rstPor_n)
    (!rstMan_n && !cfgWe) |=> $stable(cfgRdata));
  a_r9_wait_masked: assert property (@(posedge clk) disable iff (!rstPor_n)
    !cfgRdata[WAIT_SEL] |-> !waitOut);
  a_r10_no_pass_in_idle: assert property (@(posedge clk) disable iff (!rstPor_n || !rstMan_n)
    (busReady && !reqReady) |-> !busValid);
endmodule

bind bus_idle_inserter bus_idle_inserter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstPor_n(rstPor_n), .rstMan_n(rstMan_n), .cfgWe(cfgWe),
  .cfgRdata(cfgRdata), .reqValid(reqValid), .reqArea(reqArea),
  .reqWrite(reqWrite), .reqReady(reqReady), .busValid(busValid),
  .busReady(busReady), .waitOut(waitOut)
);

// File: tb/sim_bus_idle_inserter.sv
module sim_bus_idle_inserter;
  localparam int ADDR_W = 32;
  localparam int NVEC   = 15;
  // entry = {area[5:3], write[2], expected idles[1:0]}
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0,1'b0,2'd0}, {3'd0,1'b0,2'd0}, {3'd0,1'b1,2'd1}, {3'd2,1'b1,2'd1},
    {3'd2,1'b1,2'd0}, {3'd3,1'b0,2'd1}, {3'd4,1'b0,2'd2}, {3'd4,1'b1,2'd3},
    {3'd1,1'b1,2'd3}, {3'd7,1'b0,2'd0}, {3'd5,1'b0,2'd0}, {3'd5,1'b1,2'd2},
    {3'd6,1'b1,2'd2}, {3'd6,1'b0,2'd1}, {3'd6,1'b0,2'd0}
  };

  logic clk = 1'b0;
  logic rstPor_n = 1'b0, rstMan_n = 1'b1;
  logic cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0, cfgRdata;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqReady;
  logic [2:0] reqArea = '0, busArea;
  logic [ADDR_W-1:0] reqAddr = '0, busAddr;
  logic busValid, busWrite, busReady = 1'b1, waitIn = 1'b0, waitOut;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  bus_idle_inserter #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstPor_n(rstPor_n), .rstMan_n(rstMan_n), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid),
    .reqArea(reqArea), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqReady(reqReady), .busValid(busValid), .busArea(busArea),
    .busWrite(busWrite), .busAddr(busAddr), .busReady(busReady),
    .waitIn(waitIn), .waitOut(waitOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic access(input logic [2:0] area, input logic wr, input int expIdles, input string tag);
    int stalls = 0;
    logic [ADDR_W-1:0] addr = {area, 5'd0, 24'hA5A000} + ADDR_W'(expIdles);
    @(negedge clk);
    reqValid = 1'b1; reqArea = area; reqWrite = wr; reqAddr = addr;
    #1;
    while (!reqReady && stalls < 8) begin
      check(!busValid, "R10 busValid low in idle", busValid, 0);
      stalls++;
      @(negedge clk); #1;
    end
    check(stalls == expIdles, tag, stalls, expIdles);
    check(busValid && busArea == area && busWrite == wr && busAddr == addr,
          "R10 forwarded unchanged", busAddr, addr);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstPor_n = 1'b1;
        #1 check(cfgRdata == 16'hBFF3, "R8 power-on value", cfgRdata, 16'hBFF3);
        // fields: a0=00 a2=01 a3=10 a4=11 a5=10 a6=00, bit15=1
        writeCfg(16'h8B90);
        check(cfgRdata == 16'h8B90, "R5 field write", cfgRdata, 16'h8B90);
        for (int i = 0; i < NVEC; i++) begin
          string t;
          t = $sformatf("R3/R4/R5/R6/R1/R2 vector %0d idle count", i);
          access(VEC[i][5:3], VEC[i][2], int'(VEC[i][1:0]), t);
        end
        // R8: manual reset keeps register, R1: clears history
        @(negedge clk); rstMan_n = 1'b0;
        @(negedge clk); rstMan_n = 1'b1;
        #1 check(cfgRdata == 16'h8B90, "R8 manual reset keeps register", cfgRdata, 16'h8B90);
        access(3'd4, 1'b1, 0, "R1 first after manual reset");
        access(3'd4, 1'b0, 3, "R4 turnaround code 11");
        // R7 reserved bits
        writeCfg(16'hFFFF);
        check(cfgRdata == 16'hBFF3, "R7 reserved ignore all-ones", cfgRdata, 16'hBFF3);
        writeCfg(16'h400C);
        check(cfgRdata == 16'h0000, "R7 reserved only write", cfgRdata, 0);
        // code 00 on area 4 now gives 1
        access(3'd4, 1'b1, 1, "R5 code 00 gives one idle");
        // R9 wait sampling
        writeCfg(16'h8000);
        @(posedge clk); #1 waitIn = 1'b1;
        @(negedge clk); #1;
        check(waitOut == 1'b1, "R9 wait sampled at fall", waitOut, 1);
        @(posedge clk); #1 waitIn = 1'b0;
        #1 check(waitOut == 1'b1, "R9 holds until next fall", waitOut, 1);
        @(negedge clk); #1;
        check(waitOut == 1'b0, "R9 wait low after fall", waitOut, 0);
        writeCfg(16'h0000);
        @(posedge clk); #1 waitIn = 1'b1;
        @(negedge clk); #1;
        check(waitOut == 1'b0, "R9 wait ignored with bit15 clear", waitOut, 0);
        waitIn = 1'b0;
        // R8 power-on reset restores
        @(negedge clk); rstPor_n = 1'b0;
        @(negedge clk); rstPor_n = 1'b1;
        #1 check(cfgRdata == 16'hBFF3, "R8 power-on restores", cfgRdata, 16'hBFF3);
        access(3'd6, 1'b0, 0, "R1 first after power-on");
        access(3'd6, 1'b0, 0, "R2 same area same direction");
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog R10 actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule